// File: doc/BRIEF.md
# Breakpoint Trap Context Swap Unit

This unit is the breakpoint controller of a small two-priority stack processor. It holds a single enable bit that decides whether the one-byte jump with a zero offset behaves as a breakpoint. It also serves a dedicated two-byte breakpoint opcode, which always traps. Instruction fetch and the main datapath live outside the unit. They hand it a decoded opcode, the current priority and the live instruction and workspace pointers.

On a trap the unit exchanges the live pointer pair with a pair of words saved in low memory. Each priority level has its own pair of saved words. The exchange is done through a word-wide memory port as two read-then-write steps. It then presents the loaded pointers and raises `done` at the cycle count the instruction is defined to take. Because the operation is a pure exchange, the same trap both enters a debugger and returns from it. The data stack registers are never involved.

The unit also answers the flag-query opcode with a word of 1 or 0. The restart opcode clears the enable bit.

Top module: `bkpt_swap_unit`

## Requirements
- R1: After reset, and after an accepted restart opcode 0x1FF, the enable bit is clear. An accepted 0x0B3 sets it and an accepted 0x0B2 clears it.
- R2: An accepted query 0x0B4 raises `test_valid` for the single following cycle. In that cycle `test_word` is 1 if the enable bit was set when the opcode was accepted, and 0 otherwise.
- R3: An accepted 0x000 while the enable bit is clear does not trap. It pulses `plain_jump` in the following cycle and causes no memory access, and `busy` stays low.
- R4: An accepted 0x000 while the enable bit is set traps. An accepted 0x0B1 traps whatever the enable bit holds.
- R5: The saved-word addresses are fixed. High priority keeps its workspace word at 0x80000070 and its instruction word at 0x80000074. Low priority keeps its workspace word at 0x80000078 and its instruction word at 0x8000007C. No other address is ever accessed.
- R6: A trap reads the saved instruction word and then writes the live instruction pointer back to that address. It then reads the saved workspace word and writes the live workspace pointer back to that address. After that, `iptr_out` and `wptr_out` hold the two values that were read.
- R7: Counting from the accepting clock edge, a trap keeps `busy` high for exactly N cycles and raises `done` only in the last of them. N is 11 for a 0x000 trap at high priority, 13 for a 0x000 trap at low priority, 9 for 0x0B1 at high priority and 11 for 0x0B1 at low priority.
- R8: While `busy` is high, any opcode presented is ignored. This includes flag changes and further traps.
- R9: `iptr_out` and `wptr_out` reset to zero and change only during a trap. Two back-to-back traps at the same priority restore the original pointers and the original saved words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A decoded opcode is presented |
| op_code | input | 9 | Decoded opcode |
| hi_pri | input | 1 | 1 = high priority, 0 = low priority |
| iptr_in | input | DW | Live instruction pointer |
| wptr_in | input | DW | Live workspace pointer |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read request |
| iptr_out | output | DW | Instruction pointer loaded by the last trap |
| wptr_out | output | DW | Workspace pointer loaded by the last trap |
| busy | output | 1 | Trap in progress, opcodes not accepted |
| done | output | 1 | Last cycle of a trap |
| plain_jump | output | 1 | A zero jump was taken as an ordinary jump |
| test_valid | output | 1 | `test_word` is valid |
| test_word | output | DW | Result of the flag query |

## Verification
The assertions assume a memory that returns read data exactly one cycle after a read request. They also assume that `op_code` is stable in any cycle in which `op_valid` is high. The bench's memory model is registered in exactly that way. The bench drives every opcode for one whole cycle, changing it only at falling edges. The random stimulus draws only from the six opcodes the unit decodes. While a trap is running, it injects flag-changing opcodes so that the ignore rule is exercised inside the assumed envelope.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam logic [8:0] OP_JZERO = 9'h000;
    localparam logic [8:0] OP_BREAK = 9'h0B1;
    localparam logic [8:0] OP_CLR   = 9'h0B2;
    localparam logic [8:0] OP_SET   = 9'h0B3;
    localparam logic [8:0] OP_TEST  = 9'h0B4;
    localparam logic [8:0] OP_START = 9'h1FF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_I,
        ST_WR_I,
        ST_RD_W,
        ST_WR_W,
        ST_PAD
    } swap_st_e;

endpackage

// File: rtl/bkpt_flag_reg.sv
module bkpt_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic en_o
);
    logic en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (clr_i)      en_d = 1'b0;
        else if (set_i) en_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign en_o = en_q;
endmodule

// File: rtl/bkpt_slot_sel.sv
module bkpt_slot_sel #(
    parameter int unsigned AW   = 32,
    parameter logic [AW-1:0] BASE = 32'h8000_0070
) (
    input  logic          hi_pri,
    output logic [AW-1:0] wslot_o,
    output logic [AW-1:0] islot_o
);
    localparam logic [AW-1:0] HI_OFS = AW'(0);
    localparam logic [AW-1:0] LO_OFS = AW'(8);
    localparam logic [AW-1:0] I_OFS  = AW'(4);

    always_comb begin
        wslot_o = BASE + (hi_pri ? HI_OFS : LO_OFS);
        islot_o = wslot_o + I_OFS;
    end
endmodule

// File: rtl/bkpt_swap_fsm.sv
module bkpt_swap_fsm
    import bkpt_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic [DW-1:0]    live_i_i,
    input  logic [DW-1:0]    live_w_i,
    input  logic [AW-1:0]    islot_i,
    input  logic [AW-1:0]    wslot_i,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic [DW-1:0]    iptr_o,
    output logic [DW-1:0]    wptr_o,
    output logic             busy_o,
    output logic             done_o
);
    typedef struct packed {
        swap_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] total;
        logic [AW-1:0]    islot;
        logic [AW-1:0]    wslot;
        logic [DW-1:0]    live_i;
        logic [DW-1:0]    live_w;
        logic [DW-1:0]    iptr;
        logic [DW-1:0]    wptr;
    } swap_t;

    swap_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (s_q.st != ST_IDLE) s_d.cnt = s_q.cnt + 1'b1;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st     = ST_RD_I;
                    s_d.cnt    = CNT_W'(1);
                    s_d.total  = total_i;
                    s_d.islot  = islot_i;
                    s_d.wslot  = wslot_i;
                    s_d.live_i = live_i_i;
                    s_d.live_w = live_w_i;
                end
            end
            ST_RD_I: begin
                mem_req  = 1'b1;
                mem_addr = s_q.islot;
                s_d.st   = ST_WR_I;
            end
            ST_WR_I: begin
                s_d.iptr  = mem_rdata;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = s_q.islot;
                mem_wdata = s_q.live_i;
                s_d.st    = ST_RD_W;
            end
            ST_RD_W: begin
                mem_req  = 1'b1;
                mem_addr = s_q.wslot;
                s_d.st   = ST_WR_W;
            end
            ST_WR_W: begin
                s_d.wptr  = mem_rdata;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = s_q.wslot;
                mem_wdata = s_q.live_w;
                s_d.st    = ST_PAD;
            end
            ST_PAD: begin
                if (s_q.cnt == s_q.total) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign iptr_o = s_q.iptr;
    assign wptr_o = s_q.wptr;
    assign busy_o = (s_q.st != ST_IDLE);
    assign done_o = (s_q.st == ST_PAD) && (s_q.cnt == s_q.total);
endmodule

// File: rtl/bkpt_swap_unit.sv
module bkpt_swap_unit
    import bkpt_pkg::*;
#(
    parameter int unsigned   DW        = 32,
    parameter int unsigned   AW        = 32,
    parameter logic [AW-1:0] SLOT_BASE = 32'h8000_0070,
    parameter int unsigned   JZ_HI_CYC = 11,
    parameter int unsigned   JZ_LO_CYC = 13,
    parameter int unsigned   BK_HI_CYC = 9,
    parameter int unsigned   BK_LO_CYC = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [8:0]    op_code,
    input  logic          hi_pri,
    input  logic [DW-1:0] iptr_in,
    input  logic [DW-1:0] wptr_in,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] iptr_out,
    output logic [DW-1:0] wptr_out,
    output logic          busy,
    output logic          done,
    output logic          plain_jump,
    output logic          test_valid,
    output logic [DW-1:0] test_word
);
    localparam int unsigned MAX_A   = (JZ_HI_CYC > JZ_LO_CYC) ? JZ_HI_CYC : JZ_LO_CYC;
    localparam int unsigned MAX_B   = (BK_HI_CYC > BK_LO_CYC) ? BK_HI_CYC : BK_LO_CYC;
    localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic jplain;
        logic tvalid;
        logic tbit;
    } misc_t;

    misc_t m_d, m_q;

    logic             j0_en;
    logic             accept;
    logic             is_jz, is_bk;
    logic             trap_go;
    logic [CNT_W-1:0] total;
    logic [AW-1:0]    islot, wslot;

    assign accept  = op_valid && !busy;
    assign is_jz   = (op_code == OP_JZERO);
    assign is_bk   = (op_code == OP_BREAK);
    assign trap_go = accept && (is_bk || (is_jz && j0_en));

    always_comb begin
        if (is_bk) total = hi_pri ? CNT_W'(BK_HI_CYC) : CNT_W'(BK_LO_CYC);
        else       total = hi_pri ? CNT_W'(JZ_HI_CYC) : CNT_W'(JZ_LO_CYC);
    end

    always_comb begin
        m_d        = '0;
        m_d.jplain = accept && is_jz && !j0_en;
        m_d.tvalid = accept && (op_code == OP_TEST);
        m_d.tbit   = m_d.tvalid ? j0_en : m_q.tbit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign plain_jump = m_q.jplain;
    assign test_valid = m_q.tvalid;
    assign test_word  = DW'(m_q.tbit);

    bkpt_flag_reg u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (accept && (op_code == OP_SET)),
        .clr_i (accept && ((op_code == OP_CLR) || (op_code == OP_START))),
        .en_o  (j0_en)
    );

    bkpt_slot_sel #(.AW(AW), .BASE(SLOT_BASE)) u_slot (
        .hi_pri  (hi_pri),
        .wslot_o (wslot),
        .islot_o (islot)
    );

    bkpt_swap_fsm #(.DW(DW), .AW(AW), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (trap_go),
        .total_i   (total),
        .live_i_i  (iptr_in),
        .live_w_i  (wptr_in),
        .islot_i   (islot),
        .wslot_i   (wslot),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .iptr_o    (iptr_out),
        .wptr_o    (wptr_out),
        .busy_o    (busy),
        .done_o    (done)
    );
endmodule

// File: rtl/bkpt_swap_unit_chk.sv
module bkpt_swap_unit_chk #(
    parameter int unsigned   AW        = 32,
    parameter logic [AW-1:0] SLOT_BASE = 32'h8000_0070
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [8:0]    op_code,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          plain_jump,
    input logic          j0_en
);
    logic acc;
    assign acc = op_valid && !busy;

    assert_set_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op_code == 9'h0B3) |=> j0_en);
    assert_clr_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (op_code == 9'h0B2 || op_code == 9'h1FF)) |=> !j0_en);
    assert_plain_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op_code == 9'h000 && !j0_en) |=> (plain_jump && !busy && !mem_req));
    assert_break_traps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op_code == 9'h0B1) |=> busy);
    assert_slot_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr == SLOT_BASE || mem_addr == SLOT_BASE + AW'(4) ||
                     mem_addr == SLOT_BASE + AW'(8) || mem_addr == SLOT_BASE + AW'(12)));
    assert_mem_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || mem_we) |-> busy);
    assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_flag_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(j0_en));
endmodule

bind bkpt_swap_unit bkpt_swap_unit_chk #(.AW(AW), .SLOT_BASE(SLOT_BASE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .busy       (busy),
    .done       (done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .plain_jump (plain_jump),
    .j0_en      (j0_en)
);

// File: tb/bkpt_swap_unit_test.sv
`timescale 1ns/1ps
module bkpt_swap_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [8:0]  op_code = '0;
    logic        hi_pri = 1'b0;
    logic [31:0] iptr_in = '0, wptr_in = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] iptr_out, wptr_out, test_word;
    logic        busy, done, plain_jump, test_valid;

    int checks = 0;
    int errors = 0;
    logic        flag_m = 1'b0;
    logic [31:0] em [4];
    logic [31:0] mem [4];
    logic [31:0] exp_i = '0, exp_w = '0;

    always #2.5 clk = ~clk;

    bkpt_swap_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .hi_pri(hi_pri), .iptr_in(iptr_in), .wptr_in(wptr_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .iptr_out(iptr_out), .wptr_out(wptr_out), .busy(busy), .done(done),
        .plain_jump(plain_jump), .test_valid(test_valid), .test_word(test_word)
    );

    function automatic logic [31:0] init_word(input int k);
        return 32'hA500_0000 + 32'(k) * 32'h111;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) mem[k] <= init_word(k);
            mem_rdata <= '0;
        end else if (mem_req) begin
            if (mem_we) mem[mem_addr[3:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[3:2]];
        end
    end

    function automatic int exp_cycles(input logic [8:0] op, input logic hi);
        if (op == 9'h0B1) return hi ? 9 : 11;
        return hi ? 11 : 13;
    endfunction

    function automatic int slot_idx(input logic hi, input logic is_i);
        return {~hi, is_i};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [8:0] op, input logic hi, input logic [31:0] ip,
                          input logic [31:0] wp, input logic [8:0] inj);
        logic trap;
        int   n, done_at, ii, wi;
        trap = (op == 9'h0B1) || (op == 9'h000 && flag_m);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; hi_pri = hi; iptr_in = ip; wptr_in = wp;
        @(negedge clk);
        op_valid = 1'b0;
        if (trap) begin
            n = 0; done_at = -1;
            while (busy && n < 40) begin
                n++;
                if (done) done_at = n;
                if (inj != 9'h000 && n == 3) begin
                    op_valid = 1'b1; op_code = inj; iptr_in = ~ip;
                end else begin
                    op_valid = 1'b0;
                end
                @(negedge clk);
            end
            op_valid = 1'b0;
            ii = slot_idx(hi, 1'b1); wi = slot_idx(hi, 1'b0);
            exp_i = em[ii]; exp_w = em[wi];
            em[ii] = ip; em[wi] = wp;
            check("R7 busy cycles", 32'(n), 32'(exp_cycles(op, hi)));
            check("R7 done cycle", 32'(done_at), 32'(exp_cycles(op, hi)));
            check("R6 iptr_out", iptr_out, exp_i);
            check("R6 wptr_out", wptr_out, exp_w);
            for (int k = 0; k < 4; k++) check("R5 slot content", mem[k], em[k]);
            if (inj != 9'h000) begin
                @(negedge clk);
                check("R8 no second trap", {31'd0, busy}, 32'd0);
            end
        end else begin
            check("R3 no busy", {31'd0, busy}, 32'd0);
            check("R3 no mem access", {31'd0, mem_req}, 32'd0);
            check("R3 plain jump pulse", {31'd0, plain_jump}, {31'd0, op == 9'h000});
            check("R2 test valid", {31'd0, test_valid}, {31'd0, op == 9'h0B4});
            if (op == 9'h0B4) check("R2 test word", test_word, {31'd0, flag_m});
            check("R9 iptr held", iptr_out, exp_i);
            check("R9 wptr held", wptr_out, exp_w);
            if (op == 9'h0B3) flag_m = 1'b1;
            if (op == 9'h0B2 || op == 9'h1FF) flag_m = 1'b0;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [8:0] ops [6];
        ops[0] = 9'h000; ops[1] = 9'h0B1; ops[2] = 9'h0B2;
        ops[3] = 9'h0B3; ops[4] = 9'h0B4; ops[5] = 9'h1FF;
        for (int k = 0; k < 4; k++) em[k] = init_word(k);
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset busy", {31'd0, busy}, 32'd0);
        check("R9 reset iptr", iptr_out, 32'd0);
        check("R9 reset wptr", wptr_out, 32'd0);
        // R1: reset clears flag, query reads 0
        run_op(9'h0B4, 1'b1, 32'h1, 32'h2, 9'h000);
        // R3: jump with flag clear
        run_op(9'h000, 1'b1, 32'h10, 32'h20, 9'h000);
        // R4: explicit break with flag clear traps, both priorities
        run_op(9'h0B1, 1'b1, 32'h1000, 32'h2000, 9'h000);
        run_op(9'h0B1, 1'b0, 32'h3000, 32'h4000, 9'h000);
        // R1 set, then R4 enabled jump traps at both priorities
        run_op(9'h0B3, 1'b0, 32'h0, 32'h0, 9'h000);
        run_op(9'h0B4, 1'b0, 32'h0, 32'h0, 9'h000);
        run_op(9'h000, 1'b1, 32'h5000, 32'h6000, 9'h000);
        run_op(9'h000, 1'b0, 32'h7000, 32'h8000, 9'h000);
        // R9 round trip: second trap restores previous pointers
        run_op(9'h000, 1'b0, exp_i, exp_w, 9'h000);
        check("R9 round trip iptr", iptr_out, 32'h7000);
        check("R9 round trip wptr", wptr_out, 32'h8000);
        // R8: clear injected during trap is ignored
        run_op(9'h0B1, 1'b1, 32'hAAAA, 32'hBBBB, 9'h0B2);
        run_op(9'h0B4, 1'b1, 32'h0, 32'h0, 9'h000);
        // R1: restart clears flag
        run_op(9'h1FF, 1'b1, 32'h0, 32'h0, 9'h000);
        run_op(9'h0B4, 1'b1, 32'h0, 32'h0, 9'h000);
        // R8: set injected during trap is ignored
        run_op(9'h0B1, 1'b0, 32'hCCCC, 32'hDDDD, 9'h0B3);
        run_op(9'h0B4, 1'b0, 32'h0, 32'h0, 9'h000);
        // random mix
        for (int t = 0; t < 150; t++) begin
            logic [8:0] op, inj;
            op  = ops[$urandom_range(5)];
            inj = ($urandom_range(3) == 0) ? ops[$urandom_range(5, 1)] : 9'h000;
            run_op(op, 1'($urandom_range(1)), $urandom, $urandom, inj);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule